// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block sits beside the receive and transmit FIFOs of a serial port and turns their fill levels and error pulses into a single level-sensitive interrupt line. It computes a live status word straight from the current FIFO counts and two programmable trigger thresholds. It folds those level conditions, together with one-cycle event pulses, into a sticky interrupt register.

Software clears the sticky register with write-one-to-clear writes. It arms sources through a pair of strobe addresses, one that only sets mask bits and one that only clears them. The interrupt fires whenever a sticky bit is also enabled in the mask.

A small write port (`wr_en_i`, `addr_i`, `wdata_i`) updates registers on the clock edge. Reads are combinational from `addr_i` and have no side effects. The FIFOs, serial framing and the bus bridge are outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word (address 6, read-only) has these bits: bit 0 when rx count >= rx trigger, bit 1 when rx count is 0, bit 2 when rx count equals FIFO_DEPTH, bit 3 when tx count is 0, bit 4 when tx count equals FIFO_DEPTH, and bit 13 when tx count >= tx trigger. All other bits are 0. It follows the counts in the same cycle.
- R2: On every clock edge, each status bit 0 to 4 that is high sets the same bit of the sticky register. Status bit 13 sets sticky bit 10. A level that stays present re-sets its sticky bit after a clear.
- R3: Each event pulse sets its own sticky bit on the next edge, and the bit stays set once the pulse has ended. The bits are: overrun bit 5, framing bit 6, parity bit 7, timeout bit 8, modem-status change bit 9, transmit overflow bit 12.
- R4: The mask is read at address 2. A write to address 0 ORs the written value into the mask, limited to the valid bits 0-10 and 12 (mask 0x17FF). A write to address 1 clears the mask bits written as one. Writes to address 2 leave the mask unchanged.
- R5: A write to address 3 clears each sticky bit written as one. Sticky bits written as zero keep their value.
- R6: When a clear and a set reach the same sticky bit in one cycle, the bit ends up set.
- R7: `irq_o` is high exactly when some bit is set in both the mask and the sticky register.
- R8: While `rst_ni` is low, the mask and sticky registers read 0 and both trigger levels read 0x20.
- R9: The rx trigger (address 4) and tx trigger (address 5) take the low CNT_W bits of a write, read back the stored value, and are the thresholds that R1 compares against.
- R10: Reads of addresses 0, 1 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_count_i | input | CNT_W | Receive FIFO fill level |
| tx_count_i | input | CNT_W | Transmit FIFO fill level |
| evt_overrun_i | input | 1 | Receive overrun pulse |
| evt_frame_i | input | 1 | Framing error pulse |
| evt_parity_i | input | 1 | Parity error pulse |
| evt_timeout_i | input | 1 | Receive timeout pulse |
| evt_modem_i | input | 1 | Modem-status change pulse |
| evt_txovf_i | input | 1 | Transmit overflow pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the FIFO counts never exceed FIFO_DEPTH. They also assume that each write names a single address, so a set-strobe and a clear-strobe never reach the mask in the same cycle. The bench holds every count between 0 and 64 and issues one write per cycle. It drives each event as a pulse exactly one cycle long and changes inputs only on the falling edge. Under these conditions, the set-wins property and the status-to-sticky latching can be checked one edge after the input that caused them.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MSET    = 3'd0,
    ADR_MCLR    = 3'd1,
    ADR_MASK    = 3'd2,
    ADR_STICKY  = 3'd3,
    ADR_RXTRIG  = 3'd4,
    ADR_TXTRIG  = 3'd5,
    ADR_STATUS  = 3'd6
  } reg_addr_e;

  // status / sticky bit positions
  localparam int B_RX_TRIG      = 0;
  localparam int B_RX_EMPTY     = 1;
  localparam int B_RX_FULL      = 2;
  localparam int B_TX_EMPTY     = 3;
  localparam int B_TX_FULL      = 4;
  localparam int B_OVERRUN      = 5;
  localparam int B_FRAME        = 6;
  localparam int B_PARITY       = 7;
  localparam int B_TIMEOUT      = 8;
  localparam int B_MODEM        = 9;
  localparam int B_TX_TRIG_IRQ  = 10;
  localparam int B_TXOVF        = 12;
  localparam int B_TX_TRIG_STAT = 13;

  localparam logic [REG_W-1:0] IRQ_VALID = 32'h0000_17FF;
  localparam int LVL_BITS = 5;
endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int FIFO_DEPTH = 64
) (
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] level_set_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  always_comb begin
    status_o                 = '0;
    status_o[B_RX_TRIG]      = (rx_count_i >= rx_trig_i);
    status_o[B_RX_EMPTY]     = (rx_count_i == '0);
    status_o[B_RX_FULL]      = (rx_count_i == FULL_CNT);
    status_o[B_TX_EMPTY]     = (tx_count_i == '0);
    status_o[B_TX_FULL]      = (tx_count_i == FULL_CNT);
    status_o[B_TX_TRIG_STAT] = (tx_count_i >= tx_trig_i);
  end

  // tx trigger lands at a different position in the sticky word
  always_comb begin
    level_set_o                     = '0;
    level_set_o[LVL_BITS-1:0]       = status_o[LVL_BITS-1:0];
    level_set_o[B_TX_TRIG_IRQ]      = status_o[B_TX_TRIG_STAT];
  end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] VALID = IRQ_VALID
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] mask_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     bit_q <= 1'b0;
        else if (set_we_i && wdata_i[i]) bit_q <= 1'b1;
        else if (clr_we_i && wdata_i[i]) bit_q <= 1'b0;
      end
      assign mask_o[i] = bit_q;
    end else begin : g_tie
      assign mask_o[i] = 1'b0;
    end
  end

  a_r4_set_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((mask_o & $past(wdata_i & VALID)) == $past(wdata_i & VALID)));
  a_r4_clr_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((mask_o & $past(wdata_i)) == '0));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(mask_o));
endmodule

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky
  import uart_irq_pkg::*;
#(
  parameter logic [REG_W-1:0] VALID = IRQ_VALID
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] sticky_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic bit_q;
      // set has priority so a same-cycle event is never lost
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;
        else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign sticky_o[i] = bit_q;
    end else begin : g_tie
      assign sticky_o[i] = 1'b0;
    end
  end

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & VALID) != '0) |=> ((sticky_o & $past(set_i & VALID)) == $past(set_i & VALID)));
  a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((sticky_o & $past(clr_i & ~set_i)) == '0));
  a_r3_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sticky_o & ~clr_i) & ~sticky_o) == '0));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int TRIG_RST   = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   tx_count_i,
  input  logic               evt_overrun_i,
  input  logic               evt_frame_i,
  input  logic               evt_parity_i,
  input  logic               evt_timeout_i,
  input  logic               evt_modem_i,
  input  logic               evt_txovf_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o
);
  logic [CNT_W-1:0] rx_trig_q, tx_trig_q;
  logic [REG_W-1:0] status, level_set, evt_set, sticky_set, sticky_clr;
  logic [REG_W-1:0] mask, sticky;
  logic             we_mset, we_mclr, we_sticky, we_rxtrig, we_txtrig;

  assign we_mset   = wr_en_i && (addr_i == ADR_MSET);
  assign we_mclr   = wr_en_i && (addr_i == ADR_MCLR);
  assign we_sticky = wr_en_i && (addr_i == ADR_STICKY);
  assign we_rxtrig = wr_en_i && (addr_i == ADR_RXTRIG);
  assign we_txtrig = wr_en_i && (addr_i == ADR_TXTRIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_trig_q <= CNT_W'(TRIG_RST);
      tx_trig_q <= CNT_W'(TRIG_RST);
    end else begin
      if (we_rxtrig) rx_trig_q <= wdata_i[CNT_W-1:0];
      if (we_txtrig) tx_trig_q <= wdata_i[CNT_W-1:0];
    end
  end

  uart_irq_status #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_status (
    .rx_count_i (rx_count_i),
    .tx_count_i (tx_count_i),
    .rx_trig_i  (rx_trig_q),
    .tx_trig_i  (tx_trig_q),
    .status_o   (status),
    .level_set_o(level_set)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[B_OVERRUN] = evt_overrun_i;
    evt_set[B_FRAME]   = evt_frame_i;
    evt_set[B_PARITY]  = evt_parity_i;
    evt_set[B_TIMEOUT] = evt_timeout_i;
    evt_set[B_MODEM]   = evt_modem_i;
    evt_set[B_TXOVF]   = evt_txovf_i;
  end

  assign sticky_set = level_set | evt_set;
  assign sticky_clr = we_sticky ? wdata_i : '0;

  uart_irq_sticky #(.VALID(IRQ_VALID)) u_sticky (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (sticky_set),
    .clr_i   (sticky_clr),
    .sticky_o(sticky)
  );

  uart_irq_mask #(.VALID(IRQ_VALID)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_we_i(we_mset),
    .clr_we_i(we_mclr),
    .wdata_i (wdata_i),
    .mask_o  (mask)
  );

  always_comb begin
    unique case (addr_i)
      ADR_MASK:   rdata_o = mask;
      ADR_STICKY: rdata_o = sticky;
      ADR_RXTRIG: rdata_o = REG_W'(rx_trig_q);
      ADR_TXTRIG: rdata_o = REG_W'(tx_trig_q);
      ADR_STATUS: rdata_o = status;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = |(mask & sticky);

  a_r2_txtrig_remap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[B_TX_TRIG_STAT] |=> sticky[B_TX_TRIG_IRQ]);
  a_r2_rx_empty_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i == '0) |=> sticky[B_RX_EMPTY]);
  a_r7_irq_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((sticky != '0) && (mask != '0)));
  a_r9_trig_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_rxtrig |=> (rx_trig_q == $past(wdata_i[CNT_W-1:0])));
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  localparam int CW = 7;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] rx_cnt = '0, tx_cnt = '0;
  logic          e_ovr = 0, e_frm = 0, e_par = 0, e_tmo = 0, e_mdm = 0, e_txo = 0;
  logic          wr_en = 0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            n_chk = 0, n_err = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_count_i(rx_cnt), .tx_count_i(tx_cnt),
    .evt_overrun_i(e_ovr), .evt_frame_i(e_frm), .evt_parity_i(e_par),
    .evt_timeout_i(e_tmo), .evt_modem_i(e_mdm), .evt_txovf_i(e_txo),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // {rx_count, tx_count, expected status}
  localparam logic [47:0] VEC [NV] = '{
    {16'd0,  16'd0,  16'h000A},
    {16'd32, 16'd0,  16'h0009},
    {16'd64, 16'd0,  16'h000D},
    {16'd31, 16'd32, 16'h2000},
    {16'd1,  16'd64, 16'h2010},
    {16'd5,  16'd5,  16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    // R8 reset values, R10 unused reads
    #2;
    rd(3'd2, d); check("R8 mask", d, 0);
    rd(3'd3, d); check("R8 sticky", d, 0);
    rd(3'd4, d); check("R8 rx trig", d, 32'h20);
    rd(3'd5, d); check("R8 tx trig", d, 32'h20);
    check("R8 irq", {31'd0, irq}, 0);
    rd(3'd7, d); check("R10 addr7", d, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rd(3'd3, d); check("R2 empties latched", d, 32'h0000_000A);
    rd(3'd0, d); check("R10 addr0", d, 0);

    // R1 / R2 table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] es;
      @(negedge clk);
      rx_cnt = VEC[i][40:32+CW-2+1-1+1-1];
      rx_cnt = CW'(VEC[i][47:32]);
      tx_cnt = CW'(VEC[i][31:16]);
      es = {16'd0, VEC[i][15:0]};
      rd(3'd6, d); check("R1 status", d, es);
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, d);
      check("R2 sticky levels", d, (es & 32'h1F) | (es[13] ? 32'h400 : 32'h0));
    end

    // counts 5/5: no level condition active
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R5 w1c all", d, 0);

    @(negedge clk); e_ovr = 1;
    @(negedge clk); e_ovr = 0;
    @(negedge clk);
    rd(3'd3, d); check("R3 overrun bit5", d, 32'h20);
    check("R7 irq masked", {31'd0, irq}, 0);

    @(negedge clk); e_frm = 1; e_par = 1; e_tmo = 1; e_mdm = 1; e_txo = 1;
    @(negedge clk); e_frm = 0; e_par = 0; e_tmo = 0; e_mdm = 0; e_txo = 0;
    rd(3'd3, d); check("R3 event bits", d, 32'h13E0);

    wr(3'd0, 32'h20);
    rd(3'd2, d); check("R4 enable", d, 32'h20);
    check("R7 irq on", {31'd0, irq}, 1);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R4 direct write ignored", d, 32'h20);
    wr(3'd1, 32'h20);
    rd(3'd2, d); check("R4 disable", d, 0);
    check("R7 irq off", {31'd0, irq}, 0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R4 valid bits", d, 32'h17FF);
    wr(3'd3, 32'h0000_0020);
    rd(3'd3, d); check("R5 partial clear", d, 32'h13C0);
    wr(3'd3, 32'h0000_13C0);
    check("R7 irq cleared", {31'd0, irq}, 0);

    // R6 clear and set same cycle
    @(negedge clk);
    e_frm = 1; wr_en = 1; addr = 3'd3; wdata = 32'h40;
    @(negedge clk);
    e_frm = 0; wr_en = 0; wdata = '0;
    rd(3'd3, d); check("R6 set wins", d, 32'h40);
    wr(3'd3, 32'hFFFF_FFFF);

    // R9 programmable triggers
    wr(3'd4, 32'd5);
    rd(3'd4, d); check("R9 rx trig readback", d, 5);
    rd(3'd6, d); check("R9 rx trig compare", d, 32'h1);
    wr(3'd5, 32'd6);
    rd(3'd6, d); check("R9 tx below trig", d, 32'h1);
    @(negedge clk); tx_cnt = 6;
    rd(3'd6, d); check("R9 tx trig compare", d, 32'h2001);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R2 relatch with bit10", d, 32'h401);
    check("R7 irq from level", {31'd0, irq}, 1);

    // R8 async reset mid-run
    @(negedge clk); rst_n = 0; #1;
    rd(3'd2, d); check("R8 mask after reset", d, 0);
    rd(3'd3, d); check("R8 sticky after reset", d, 0);
    rd(3'd4, d); check("R8 rx trig after reset", d, 32'h20);
    finish_run();
  end
endmodule